// File: doc/BRIEF.md
# Sampling Converter Conversion Controller

This block is the digital control side of a sampling analog-to-digital converter, running on one clock. It takes a sync-mode select, an active-low chip select, an active-low start-convert request and an active-low status enable. From these it decides when a conversion begins. It then runs a conversion of fixed length and reports progress on an end-of-convert status pin and a track/hold indication. When a conversion finishes, it emits a one-cycle done strobe together with the converted word, which it captures from a supplied result input.

There are two start modes. With sync mode selected, a start needs both chip select and start-convert low. With sync mode off, start-convert alone starts a conversion and chip select has no effect. In both modes the request must stay low for a minimum number of clock cycles to count. The status pin is modelled as a level plus an output enable, and its drive style depends on the mode:

- In sync mode it behaves as a three-state output, gated by chip select and status enable.
- With sync mode off it behaves as an open-drain output that only pulls low while a conversion is running.

The sequencer is a three-state machine:

- `SEQ_IDLE` (waiting, sampler tracking).
- `SEQ_HOLD` (first `TRACK_AT` cycles of a conversion, sampler holding).
- `SEQ_ACQ` (the rest of the conversion, sampler back in track for the next sample).

The transitions are:

- **start**: IDLE to HOLD, when the request is qualified.
- **release**: HOLD to ACQ, after `TRACK_AT` cycles.
- **finish**: ACQ to IDLE, after `CONV_CYCLES` cycles in total, with no request pending.
- **chain**: ACQ to HOLD, at the same point, when the request is still held.

Top module: `conv_ctrl`

## Requirements
- R1: With sync_mode_i=1, a conversion starts only after cs_n_i=0 and start_n_i=0 have both been sampled together on MIN_PULSE consecutive rising edges (default 2). The conversion begins on the edge of the MIN_PULSE-th sample. With cs_n_i=1, no conversion starts.
- R2: With sync_mode_i=0, start_n_i=0 sampled on MIN_PULSE consecutive edges starts a conversion whatever the level of cs_n_i.
- R3: A start request that lasts fewer than MIN_PULSE sampled cycles starts no conversion.
- R4: A conversion lasts CONV_CYCLES cycles (default 16). At the edge that ends it, done_o pulses high for one cycle and done_data_o carries the value of result_i sampled at that edge.
- R5: track_o is 0 for the first TRACK_AT cycles of a conversion (default 10) and 1 from then until the conversion ends, and while idle.
- R6: A start request that both begins and ends inside a running conversion has no effect: the block is idle after that conversion finishes.
- R7: If the start condition is still held when a conversion ends, the next conversion starts on that same edge with no idle cycle. done_o still pulses, and track_o returns to 0.
- R8: With sync_mode_i=1, eoc_oe_o = 1 exactly when cs_n_i=0 and stat_en_n_i=0. eoc_o is 0 while a conversion runs and 1 otherwise.
- R9: With sync_mode_i=0, eoc_oe_o = 1 exactly when stat_en_n_i=0 and a conversion runs, and eoc_o is then 0.
- R10: eoc_o is 0 whenever eoc_oe_o is 0.
- R11: After reset the block is idle: track_o=1 and done_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode_i | input | 1 | 1 = start qualified by chip select; 0 = chip select ignored |
| cs_n_i | input | 1 | Active-low chip select |
| start_n_i | input | 1 | Active-low start-convert request |
| stat_en_n_i | input | 1 | Active-low enable for the status pin |
| result_i | input | RES_W (12) | Converted word captured at the end of a conversion |
| eoc_o | output | 1 | Status pin level (0 = converting when driven) |
| eoc_oe_o | output | 1 | Status pin drive enable |
| track_o | output | 1 | 1 = sampler tracking, 0 = holding |
| done_o | output | 1 | One-cycle strobe at the end of a conversion |
| done_data_o | output | RES_W (12) | Word captured with the done strobe |

## Verification
A sequencer stuck in the wrong state shows up on track_o and on the status pin at once, because both follow the state with no register in between. A cycle counter that is off by one moves the rising edge of track_o, or the done strobe, by exactly one cycle from the positions the requirements fix. A wrong mode decode in the status logic flips eoc_oe_o in the same cycle that the inputs change. A qualifier that is too eager or too strict shows as a start one edge early or late, or as a short pulse that begins a conversion.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_ACQ  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/conv_start_qual.sv
module conv_start_qual #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode_i,
    input  logic cs_n_i,
    input  logic start_n_i,
    output logic start_ok_o
);

    logic req;

    // Chip select only qualifies the request in sync mode.
    assign req = !start_n_i && (!sync_mode_i || !cs_n_i);

    generate
        if (MIN_PULSE <= 1) begin : g_direct
            assign start_ok_o = req;
        end else begin : g_count
            localparam int CNT_W = $clog2(MIN_PULSE + 1);
            localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(MIN_PULSE - 1);
            logic [CNT_W-1:0] run_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    run_q <= '0;
                end else if (!req) begin
                    run_q <= '0;
                end else if (run_q < CNT_ARM) begin
                    run_q <= run_q + 1'b1;
                end
            end

            assign start_ok_o = req && (run_q >= CNT_ARM);

            // R3: a qualified request was already present one edge earlier
            assert_min_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
                start_ok_o |-> $past(req));
        end
    endgenerate

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_ctrl_pkg::*;
#(
    parameter int CONV_CYCLES = 16,
    parameter int TRACK_AT    = 10,
    parameter int RES_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok_i,
    input  logic [RES_W-1:0] result_i,
    output logic             converting_o,
    output logic             track_o,
    output logic             done_o,
    output logic [RES_W-1:0] done_data_o
);

    localparam int CYC_W = $clog2(CONV_CYCLES);
    localparam logic [CYC_W-1:0] CYC_REL  = CYC_W'(TRACK_AT - 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CONV_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CYC_W-1:0] cyc_q, cyc_d;
    logic             finish;
    logic             done_q;
    logic [RES_W-1:0] data_q;

    initial begin
        if (TRACK_AT < 1 || TRACK_AT >= CONV_CYCLES)
            $error("TRACK_AT must lie inside the conversion window");
    end

    assign finish = (state_q == SEQ_ACQ) && (cyc_q == CYC_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cyc_d   = cyc_q;
        unique case (state_q)
            SEQ_IDLE: begin
                cyc_d = '0;
                if (start_ok_i) state_d = SEQ_HOLD;          // start
            end
            SEQ_HOLD: begin
                cyc_d = cyc_q + 1'b1;
                if (cyc_q == CYC_REL) state_d = SEQ_ACQ;     // release
            end
            SEQ_ACQ: begin
                cyc_d = cyc_q + 1'b1;
                if (cyc_q == CYC_LAST) begin
                    cyc_d   = '0;
                    state_d = start_ok_i ? SEQ_HOLD           // chain
                                         : SEQ_IDLE;          // finish
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                cyc_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            cyc_q   <= cyc_d;
        end
    end

    // done strobe and captured word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            done_q <= finish;
            if (finish) data_q <= result_i;
        end
    end

    // outputs
    always_comb begin
        converting_o = (state_q != SEQ_IDLE);
        track_o      = (state_q != SEQ_HOLD);
        done_o       = done_q;
        done_data_o  = data_q;
    end

    // R4: the done strobe lasts one cycle
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R5: the sampler is back in track when a conversion completes
    assert_track_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(track_o));

    // R1: no conversion leaves idle without a qualified request
    assert_idle_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && !start_ok_i) |=> !converting_o);

    // R7: a request held at the end of a conversion chains straight into hold
    assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && start_ok_i) |=> (converting_o && !track_o));

endmodule

// File: rtl/conv_status_drv.sv
module conv_status_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode_i,
    input  logic cs_n_i,
    input  logic stat_en_n_i,
    input  logic converting_i,
    output logic eoc_o,
    output logic eoc_oe_o
);

    logic level;

    always_comb begin
        if (sync_mode_i) begin
            // three-state style: selected and enabled, show busy/free
            eoc_oe_o = !cs_n_i && !stat_en_n_i;
            level    = !converting_i;
        end else begin
            // open-drain style: only ever pulls low while busy
            eoc_oe_o = !stat_en_n_i && converting_i;
            level    = 1'b0;
        end
        eoc_o = eoc_oe_o && level;
    end

    // R8: a deselected part never drives the status pin in sync mode
    assert_sync_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode_i && cs_n_i) |-> !eoc_oe_o);

    // R9: open-drain drive only pulls low during a conversion
    assert_async_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode_i && eoc_oe_o) |-> (!eoc_o && converting_i));

    // R10: undriven pin reads 0
    assert_float_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_oe_o |-> !eoc_o);

endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl #(
    parameter int CONV_CYCLES = 16,
    parameter int TRACK_AT    = 10,
    parameter int MIN_PULSE   = 2,
    parameter int RES_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode_i,
    input  logic             cs_n_i,
    input  logic             start_n_i,
    input  logic             stat_en_n_i,
    input  logic [RES_W-1:0] result_i,
    output logic             eoc_o,
    output logic             eoc_oe_o,
    output logic             track_o,
    output logic             done_o,
    output logic [RES_W-1:0] done_data_o
);

    logic start_ok;
    logic converting;

    conv_start_qual #(
        .MIN_PULSE (MIN_PULSE)
    ) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_mode_i (sync_mode_i),
        .cs_n_i      (cs_n_i),
        .start_n_i   (start_n_i),
        .start_ok_o  (start_ok)
    );

    conv_sequencer #(
        .CONV_CYCLES (CONV_CYCLES),
        .TRACK_AT    (TRACK_AT),
        .RES_W       (RES_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_ok_i   (start_ok),
        .result_i     (result_i),
        .converting_o (converting),
        .track_o      (track_o),
        .done_o       (done_o),
        .done_data_o  (done_data_o)
    );

    conv_status_drv u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_mode_i  (sync_mode_i),
        .cs_n_i       (cs_n_i),
        .stat_en_n_i  (stat_en_n_i),
        .converting_i (converting),
        .eoc_o        (eoc_o),
        .eoc_oe_o     (eoc_oe_o)
    );

    // R11: reset leaves the sampler tracking and no strobe pending
    assert_reset_idle_R11: assert property (@(posedge clk)
        $rose(rst_n) |-> (track_o && !done_o));

endmodule

// File: tb/conv_ctrl_tb.sv
module conv_ctrl_tb;

    localparam int CONV = 16;
    localparam int TRK  = 10;
    localparam int MINP = 2;
    localparam logic [11:0] RES = 12'hA5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_mode = 1'b1;
    logic        cs_n = 1'b1;
    logic        start_n = 1'b1;
    logic        stat_en_n = 1'b0;
    logic [11:0] result = RES;
    logic        eoc, eoc_oe, track, done;
    logic [11:0] done_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    conv_ctrl #(
        .CONV_CYCLES (CONV),
        .TRACK_AT    (TRK),
        .MIN_PULSE   (MINP),
        .RES_W       (12)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_mode_i (sync_mode),
        .cs_n_i      (cs_n),
        .start_n_i   (start_n),
        .stat_en_n_i (stat_en_n),
        .result_i    (result),
        .eoc_o       (eoc),
        .eoc_oe_o    (eoc_oe),
        .track_o     (track),
        .done_o      (done),
        .done_data_o (done_data)
    );

    // {converting, sync, cs_n, en_n, expected oe, expected eoc}
    localparam logic [5:0] STAT_VEC [16] = '{
        6'b0_1_0_0_1_1, 6'b0_1_0_1_0_0, 6'b0_1_1_0_0_0, 6'b0_1_1_1_0_0,
        6'b0_0_0_0_0_0, 6'b0_0_0_1_0_0, 6'b0_0_1_0_0_0, 6'b0_0_1_1_0_0,
        6'b1_1_0_0_1_0, 6'b1_1_0_1_0_0, 6'b1_1_1_0_0_0, 6'b1_1_1_1_0_0,
        6'b1_0_0_0_1_0, 6'b1_0_0_1_0_0, 6'b1_0_1_0_1_0, 6'b1_0_1_1_0_0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // drive a request at a falling edge; returns just after the start edge
    task automatic begin_conv();
        @(negedge clk);
        start_n = 1'b0;
        cycles(MINP);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        check("R11 track after reset", track, 1);
        check("R11 done after reset", done, 0);

        // status truth tables (R8 R9 R10)
        for (int i = 0; i < 16; i++) begin
            if (i == 8) begin
                sync_mode = 1'b0;
                begin_conv();
                start_n = 1'b1;
            end
            @(negedge clk);
            sync_mode = STAT_VEC[i][4];
            cs_n      = STAT_VEC[i][3];
            stat_en_n = STAT_VEC[i][2];
            #1;
            check(STAT_VEC[i][4] ? "R8 oe" : "R9 oe", eoc_oe, STAT_VEC[i][1]);
            check(STAT_VEC[i][4] ? "R8 level" : "R10 level", eoc, STAT_VEC[i][0]);
        end
        cycles(CONV + 4);

        // R1/R4/R5 sync-mode start and timing
        sync_mode = 1'b1; cs_n = 1'b0; stat_en_n = 1'b0;
        cycles(1);
        @(negedge clk); start_n = 1'b0;
        cycles(MINP - 1);
        check("R1 not yet started", track, 1);
        cycles(1);
        check("R1 started hold", track, 0);
        check("R8 eoc busy", eoc, 0);
        start_n = 1'b1;
        cycles(TRK - 1);
        check("R5 still hold", track, 0);
        cycles(1);
        check("R5 back to track", track, 1);
        cycles(CONV - TRK - 1);
        check("R4 still busy", eoc, 0);
        check("R4 no early done", done, 0);
        cycles(1);
        check("R4 eoc free", eoc, 1);
        check("R4 done strobe", done, 1);
        check("R4 done data", done_data, RES);
        cycles(1);
        check("R4 done single", done, 0);

        // R1 sync mode with chip select high
        cs_n = 1'b1;
        @(negedge clk); start_n = 1'b0;
        cycles(6);
        check("R1 deselected no start", track, 1);
        start_n = 1'b1;
        cycles(2);

        // R2 async start ignores chip select
        sync_mode = 1'b0; cs_n = 1'b1;
        begin_conv();
        check("R2 async start", track, 0);
        start_n = 1'b1;
        cycles(CONV + 2);

        // R3 short pulse
        @(negedge clk); start_n = 1'b0;
        @(negedge clk); start_n = 1'b1;
        cycles(4);
        check("R3 short pulse", track, 1);
        check("R3 no done", done, 0);

        // R6 request inside a conversion
        begin_conv();
        start_n = 1'b1;
        cycles(3);
        start_n = 1'b0;
        cycles(3);
        start_n = 1'b1;
        cycles(CONV - 6);
        check("R6 done", done, 1);
        cycles(2);
        check("R6 idle after", track, 1);
        stat_en_n = 1'b0;
        #1;
        check("R6 not driving", eoc_oe, 0);

        // R7 continuous conversion
        result = 12'h3C1;
        begin_conv();
        cycles(CONV);
        check("R7 done on chain", done, 1);
        check("R7 data on chain", done_data, 12'h3C1);
        check("R7 hold again", track, 0);
        check("R7 still driving busy", eoc_oe, 1);
        start_n = 1'b1;
        cycles(CONV + 2);
        check("R7 idle at end", track, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule